// File: doc/BRIEF.md
# Timeslot Synchronous Transfer Interrupt Generator

This block watches a time-division-multiplexed serial frame and raises a synchronous-transfer interrupt for each of four channel access registers shortly after that register's programmed timeslot has passed. A microcontroller uses the interrupt to know when it may safely read or write the register's data. If the controller has not acknowledged a pending transfer interrupt by the time another enabled transfer interrupt arrives, an overflow interrupt is raised for the late pair.

The frame timer counts data clocks from a frame sync pulse. A timeslot lasts eight bit clocks, and one bit clock is two data clocks, so one timeslot is sixteen data clocks. Each register pair has a timeslot select and a late/early position select that place its interrupt one or two bit clocks after the end of the chosen timeslot. Transfer interrupts depend on the input-direction enable of the register, overflow interrupts on its output-direction enable, and each kind has its own mask. A combined interrupt line is the OR of all unmasked pending flags.

Each pair is held by a four-state machine: PR_IDLE (nothing pending), PR_STI (transfer pending), PR_BOTH (transfer and overflow pending), PR_OVF (only overflow pending). Transitions: a transfer event moves PR_IDLE to PR_STI; an acknowledge moves PR_STI to PR_IDLE and PR_BOTH to PR_OVF; an overflow event moves PR_STI to PR_BOTH (or to PR_OVF when acknowledged in the same cycle); an overflow clear moves PR_BOTH to PR_STI and PR_OVF to PR_IDLE; a transfer event moves PR_OVF to PR_BOTH. The frame timer has two states: FR_HUNT (no frame sync seen yet, counter held at zero) and FR_RUN (counting); a frame sync moves FR_HUNT to FR_RUN and restarts the count in either state.

Top module: `tsi_gen`

## Requirements
- R1: After a cycle with `fsync_i` high, the frame count restarts at 0 and then advances by one per clock, wrapping modulo 512 (32 timeslots of 16 clocks each).
- R2: For pair p with timeslot select `ts` (bits [5p+4:5p] of `ts_sel_i`), the transfer event occurs when the frame count equals (16*ts + 19) mod 512 with `late_sel_i[p]`=0, or (16*ts + 17) mod 512 with `late_sel_i[p]`=1; `sti_stat_o[p]` is high after the following clock edge.
- R3: A transfer event sets `sti_stat_o[p]` only while `in_en_i[p]`=1 and `sti_mask_i[p]`=0; output enable alone never sets it.
- R4: `stov_stat_o[p]` can only be set while `out_en_i[p]`=1 and `stov_mask_i[p]`=0.
- R5: `stov_stat_o[p]` is set when any pair (including p) has an enabled transfer event while `sti_stat_o[p]`=1 and pair p's transfer interrupt is enabled; a masked or disabled transfer event causes no overflow.
- R6: Writing 1 to `sti_ack_i[p]` clears `sti_stat_o[p]` on the next edge, except that a transfer event of pair p in the same cycle keeps it set.
- R7: `stov_stat_o[p]` is cleared by `stov_rd_i` (all pairs) or by `stov_ack_i[p]`; an overflow event in the same cycle keeps it set.
- R8: `irq_o` is high exactly when some pending transfer flag has its mask at 0 or some pending overflow flag has its mask at 0.
- R9: After reset all flags and `irq_o` are 0, and no event occurs before the first frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fsync_i | input | 1 | Frame sync pulse, restarts the frame count |
| ts_sel_i | input | 20 | Timeslot select per pair, 5 bits each, pair p at [5p+4:5p] |
| late_sel_i | input | 4 | Position select per pair: 0 = two bit clocks after slot, 1 = one |
| in_en_i | input | 4 | Input-direction enable per pair |
| out_en_i | input | 4 | Output-direction enable per pair |
| sti_mask_i | input | 4 | Transfer interrupt mask per pair (1 = masked) |
| stov_mask_i | input | 4 | Overflow interrupt mask per pair (1 = masked) |
| sti_ack_i | input | 4 | Write-1 acknowledge of transfer flags |
| stov_ack_i | input | 4 | Write-1 acknowledge of overflow flags |
| stov_rd_i | input | 1 | Overflow status read strobe, clears all overflow flags |
| sti_stat_o | output | 4 | Pending transfer flags |
| stov_stat_o | output | 4 | Pending overflow flags |
| irq_o | output | 1 | Combined interrupt |

## Verification
Every flag is one register away from its cause: with a frame sync sampled at edge E0, a transfer event at count T is visible after edge E0+T+1, and an acknowledge or read strobe takes effect after the single edge that samples it. The bench drives inputs on falling edges, steps one full clock at a time while tracking the count since sync, and samples on the falling edge after the expected rising edge; the timing sweep records the first cycle at which the flag appears and compares it with the arithmetic target, so a flag that arrives one cycle early or late is reported.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    // Frame timer states
    typedef enum logic {
        FR_HUNT = 1'b0,
        FR_RUN  = 1'b1
    } frame_state_e;

    // Per-pair flag states
    typedef enum logic [1:0] {
        PR_IDLE = 2'b00,
        PR_STI  = 2'b01,
        PR_BOTH = 2'b11,
        PR_OVF  = 2'b10
    } pair_state_e;

    function automatic pair_state_e pair_pick(input logic keep_sti, input logic keep_ovf);
        pair_state_e s;
        unique case ({keep_ovf, keep_sti})
            2'b00:   s = PR_IDLE;
            2'b01:   s = PR_STI;
            2'b11:   s = PR_BOTH;
            default: s = PR_OVF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
    import tsi_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fsync_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o
);

    frame_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= FR_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_HUNT: if (fsync_i) state_d = FR_RUN;
            FR_RUN:  state_d = FR_RUN;
        endcase
    end

    // Frame count
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (fsync_i) begin
            cnt_q <= '0;
        end else if (state_q == FR_RUN) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        cnt_o = cnt_q;
        run_o = (state_q == FR_RUN);
    end

endmodule

// File: rtl/tsi_slot_match.sv
module tsi_slot_match #(
    parameter int NPAIR    = 4,
    parameter int TS_W     = 5,
    parameter int TS_BITS  = 8,
    parameter int BIT_DCL  = 2,
    localparam int SLOT_DCL = TS_BITS * BIT_DCL,
    localparam int SLOT_LSB = $clog2(SLOT_DCL),
    localparam int CNT_W    = TS_W + SLOT_LSB
) (
    input  logic [CNT_W-1:0]      cnt_i,
    input  logic                  run_i,
    input  logic [NPAIR*TS_W-1:0] ts_sel_i,
    input  logic [NPAIR-1:0]      late_sel_i,
    output logic [NPAIR-1:0]      hit_o
);

    // Offsets from slot start: last clock of the slot plus one or two bit clocks
    localparam logic [CNT_W-1:0] OFS_NEAR = CNT_W'(SLOT_DCL - 1 + BIT_DCL);
    localparam logic [CNT_W-1:0] OFS_FAR  = CNT_W'(SLOT_DCL - 1 + 2 * BIT_DCL);

    for (genvar g = 0; g < NPAIR; g++) begin : g_cmp
        logic [TS_W-1:0]  ts;
        logic [CNT_W-1:0] base;
        logic [CNT_W-1:0] tgt;
        always_comb begin
            ts       = ts_sel_i[g*TS_W +: TS_W];
            base     = {ts, {SLOT_LSB{1'b0}}};
            tgt      = base + (late_sel_i[g] ? OFS_NEAR : OFS_FAR);
            hit_o[g] = run_i && (cnt_i == tgt);
        end
    end

endmodule

// File: rtl/tsi_pair_fsm.sv
module tsi_pair_fsm
    import tsi_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sti_evt_i,
    input  logic ovf_evt_i,
    input  logic sti_ack_i,
    input  logic ovf_clr_i,
    output logic sti_o,
    output logic stov_o
);

    pair_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a new event always beats a clear in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PR_IDLE: begin
                state_d = pair_pick(sti_evt_i, ovf_evt_i);
            end
            PR_STI: begin
                state_d = pair_pick(sti_evt_i || !sti_ack_i, ovf_evt_i);
            end
            PR_BOTH: begin
                state_d = pair_pick(sti_evt_i || !sti_ack_i, ovf_evt_i || !ovf_clr_i);
            end
            PR_OVF: begin
                state_d = pair_pick(sti_evt_i, ovf_evt_i || !ovf_clr_i);
            end
        endcase
    end

    // Outputs
    always_comb begin
        sti_o  = (state_q == PR_STI) || (state_q == PR_BOTH);
        stov_o = (state_q == PR_OVF) || (state_q == PR_BOTH);
    end

endmodule

// File: rtl/tsi_gen.sv
module tsi_gen #(
    parameter int NPAIR   = 4,
    parameter int TS_W    = 5,
    parameter int TS_BITS = 8,
    parameter int BIT_DCL = 2,
    localparam int CNT_W  = TS_W + $clog2(TS_BITS * BIT_DCL)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  fsync_i,
    input  logic [NPAIR*TS_W-1:0] ts_sel_i,
    input  logic [NPAIR-1:0]      late_sel_i,
    input  logic [NPAIR-1:0]      in_en_i,
    input  logic [NPAIR-1:0]      out_en_i,
    input  logic [NPAIR-1:0]      sti_mask_i,
    input  logic [NPAIR-1:0]      stov_mask_i,
    input  logic [NPAIR-1:0]      sti_ack_i,
    input  logic [NPAIR-1:0]      stov_ack_i,
    input  logic                  stov_rd_i,
    output logic [NPAIR-1:0]      sti_stat_o,
    output logic [NPAIR-1:0]      stov_stat_o,
    output logic                  irq_o
);

    logic [CNT_W-1:0] cnt;
    logic             run;
    logic [NPAIR-1:0] hit;
    logic [NPAIR-1:0] sti_en;
    logic [NPAIR-1:0] stov_en;
    logic [NPAIR-1:0] sti_evt;
    logic [NPAIR-1:0] ovf_evt;
    logic             any_evt;

    tsi_frame_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fsync_i (fsync_i),
        .cnt_o   (cnt),
        .run_o   (run)
    );

    tsi_slot_match #(
        .NPAIR   (NPAIR),
        .TS_W    (TS_W),
        .TS_BITS (TS_BITS),
        .BIT_DCL (BIT_DCL)
    ) u_match (
        .cnt_i      (cnt),
        .run_i      (run),
        .ts_sel_i   (ts_sel_i),
        .late_sel_i (late_sel_i),
        .hit_o      (hit)
    );

    // Enables: transfer side follows the input direction, overflow side the output
    always_comb begin
        sti_en  = in_en_i & ~sti_mask_i;
        stov_en = out_en_i & ~stov_mask_i;
        sti_evt = hit & sti_en;
        any_evt = |sti_evt;
        ovf_evt = {NPAIR{any_evt}} & stov_en & sti_en & sti_stat_o;
    end

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        tsi_pair_fsm u_fsm (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .sti_evt_i (sti_evt[g]),
            .ovf_evt_i (ovf_evt[g]),
            .sti_ack_i (sti_ack_i[g]),
            .ovf_clr_i (stov_ack_i[g] | stov_rd_i),
            .sti_o     (sti_stat_o[g]),
            .stov_o    (stov_stat_o[g])
        );
    end

    always_comb begin
        irq_o = |(sti_stat_o & ~sti_mask_i) | |(stov_stat_o & ~stov_mask_i);
    end

endmodule

// File: rtl/tsi_gen_chk.sv
module tsi_gen_chk #(
    parameter int NPAIR = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [NPAIR-1:0] in_en_i,
    input logic [NPAIR-1:0] out_en_i,
    input logic [NPAIR-1:0] sti_mask_i,
    input logic [NPAIR-1:0] stov_mask_i,
    input logic [NPAIR-1:0] sti_ack_i,
    input logic [NPAIR-1:0] stov_ack_i,
    input logic             stov_rd_i,
    input logic [NPAIR-1:0] sti_stat_o,
    input logic [NPAIR-1:0] stov_stat_o,
    input logic             irq_o
);

    for (genvar g = 0; g < NPAIR; g++) begin : g_chk
        // R3
        p_sti_needs_input_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(sti_stat_o[g]) |-> $past(in_en_i[g] && !sti_mask_i[g]));
        // R4
        p_stov_needs_output_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(stov_stat_o[g]) |-> $past(out_en_i[g] && !stov_mask_i[g]));
        // R5
        p_stov_needs_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(stov_stat_o[g]) |-> $past(sti_stat_o[g] && in_en_i[g] && !sti_mask_i[g]));
        // R6
        p_sti_clear_by_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(sti_stat_o[g]) |-> $past(sti_ack_i[g]));
        // R7
        p_stov_clear_by_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(stov_stat_o[g]) |-> $past(stov_ack_i[g] || stov_rd_i));
    end

    // R8
    p_irq_has_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((sti_stat_o != '0) || (stov_stat_o != '0)));

endmodule

bind tsi_gen tsi_gen_chk #(.NPAIR(NPAIR)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_en_i     (in_en_i),
    .out_en_i    (out_en_i),
    .sti_mask_i  (sti_mask_i),
    .stov_mask_i (stov_mask_i),
    .sti_ack_i   (sti_ack_i),
    .stov_ack_i  (stov_ack_i),
    .stov_rd_i   (stov_rd_i),
    .sti_stat_o  (sti_stat_o),
    .stov_stat_o (stov_stat_o),
    .irq_o       (irq_o)
);

// File: tb/tsi_gen_tb_top.sv
`timescale 1ns/1ps
module tsi_gen_tb_top;

    localparam int NP = 4;
    localparam int TW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fsync = 1'b0;
    logic [NP*TW-1:0] ts_sel = '0;
    logic [NP-1:0] late_sel = '0;
    logic [NP-1:0] in_en = '0;
    logic [NP-1:0] out_en = '0;
    logic [NP-1:0] sti_mask = '0;
    logic [NP-1:0] stov_mask = '0;
    logic [NP-1:0] sti_ack = '0;
    logic [NP-1:0] stov_ack = '0;
    logic          stov_rd = 1'b0;
    logic [NP-1:0] sti_stat;
    logic [NP-1:0] stov_stat;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    int c = 0;   // clocks since last frame sync
    bit done = 1'b0;

    always #2 clk = ~clk;

    tsi_gen dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .fsync_i     (fsync),
        .ts_sel_i    (ts_sel),
        .late_sel_i  (late_sel),
        .in_en_i     (in_en),
        .out_en_i    (out_en),
        .sti_mask_i  (sti_mask),
        .stov_mask_i (stov_mask),
        .sti_ack_i   (sti_ack),
        .stov_ack_i  (stov_ack),
        .stov_rd_i   (stov_rd),
        .sti_stat_o  (sti_stat),
        .stov_stat_o (stov_stat),
        .irq_o       (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            c++;
        end
    endtask

    task automatic go_to(input int t);
        step(t - c);
    endtask

    task automatic sync();
        fsync = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fsync = 1'b0;
        c = 0;
    endtask

    task automatic clean();
        in_en = '0; out_en = '0; sti_mask = '0; stov_mask = '0;
        sti_ack = '1; stov_rd = 1'b1;
        step(1);
        sti_ack = '0; stov_rd = 1'b0;
    endtask

    function automatic int tgt(input int ts, input int late);
        return (16 * ts + 15 + (late != 0 ? 2 : 4)) % 512;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int tsl[8] = '{0, 1, 7, 13, 20, 26, 30, 31};
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 sti reset", int'(sti_stat), 0);
        check("R9 stov reset", int'(stov_stat), 0);
        check("R9 irq reset", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 no event before first frame sync
        in_en[0] = 1'b1;
        step(600);
        check("R9 no sync no sti", int'(sti_stat), 0);
        clean();

        // R1 R2 timing sweep
        for (int p = 0; p < NP; p++) begin
            for (int l = 0; l < 2; l++) begin
                for (int k = 0; k < 8; k++) begin
                    int seen;
                    ts_sel = '0;
                    ts_sel[p*TW +: TW] = TW'(tsl[k]);
                    late_sel = '0;
                    late_sel[p] = l[0];
                    sync();
                    in_en[p] = 1'b1;
                    seen = -1;
                    for (int i = 1; i <= 600; i++) begin
                        step(1);
                        if (sti_stat[p] && seen < 0) seen = i;
                        if (seen >= 0) break;
                    end
                    check("R2 R1 sti cycle", seen, tgt(tsl[k], l) + 1);
                    check("R2 only own flag", int'(sti_stat), 1 << p);
                    check("R8 irq on sti", int'(irq), 1);
                    clean();
                end
            end
        end

        // R3 output enable alone, then masked input
        ts_sel = '0; ts_sel[1*TW +: TW] = 5'd2; late_sel = '0;
        out_en[1] = 1'b1;
        sync();
        step(520);
        check("R3 out only no sti", int'(sti_stat), 0);
        check("R3 out only no irq", int'(irq), 0);
        in_en[1] = 1'b1; sti_mask[1] = 1'b1;
        sync();
        step(520);
        check("R3 masked no sti", int'(sti_stat), 0);
        check("R3 masked no stov", int'(stov_stat), 0);
        clean();

        // R5 overflow from another pair; pair0 slot0 (19), pair1 slot2 (51)
        ts_sel = '0; ts_sel[1*TW +: TW] = 5'd2; late_sel = '0;
        sync();
        in_en = 4'b0011; out_en = 4'b0001;
        go_to(53);
        check("R5 both sti", int'(sti_stat), 3);
        check("R5 stov pair0", int'(stov_stat), 1);
        // R7 read strobe clears overflow only
        stov_rd = 1'b1; step(1); stov_rd = 1'b0;
        check("R7 read clears stov", int'(stov_stat), 0);
        check("R7 read keeps sti", int'(sti_stat), 3);
        // R5 own recurrence in next frame (count 512+19 -> seen after 532)
        go_to(532);
        check("R5 own recurrence stov", int'(stov_stat[0]), 1);
        // R8 masking stov drops irq contribution; mask sti too
        stov_ack[1] = 1'b1; step(1); stov_ack[1] = 1'b0;
        // R7 per-pair ack
        stov_ack[0] = 1'b1; step(1); stov_ack[0] = 1'b0;
        check("R7 ack clears stov", int'(stov_stat), 0);
        sti_mask = 4'b0011;
        @(posedge clk); @(negedge clk); c++;
        check("R8 masked pending no irq", int'(irq), 0);
        check("R8 flag stays while masked", int'(sti_stat), 3);
        sti_mask = 4'b0010;
        #0;
        @(posedge clk); @(negedge clk); c++;
        check("R8 unmasked irq", int'(irq), 1);
        clean();

        // R4 no output enable -> no overflow
        sync();
        in_en = 4'b0011; out_en = 4'b0000;
        go_to(53);
        check("R4 no out_en no stov", int'(stov_stat), 0);
        clean();
        // R4 overflow masked
        sync();
        in_en = 4'b0011; out_en = 4'b0001; stov_mask = 4'b0001;
        go_to(53);
        check("R4 masked stov", int'(stov_stat), 0);
        clean();
        // R5 masked transfer of pair1 causes no overflow
        sync();
        in_en = 4'b0011; out_en = 4'b0001; sti_mask = 4'b0010;
        go_to(53);
        check("R5 masked sti no stov", int'(stov_stat), 0);
        check("R5 pair0 pending", int'(sti_stat), 1);
        clean();

        // R6 ack clears; pair0 slot0 late (17)
        ts_sel = '0; late_sel = 4'b0001;
        sync();
        in_en[0] = 1'b1;
        go_to(18);
        check("R6 sti set", int'(sti_stat[0]), 1);
        sti_ack[0] = 1'b1; step(1); sti_ack[0] = 1'b0;
        check("R6 ack clears", int'(sti_stat[0]), 0);
        // R6 event and ack in the same cycle: event wins
        go_to(529);
        sti_ack[0] = 1'b1; step(1); sti_ack[0] = 1'b0;
        check("R6 event beats ack", int'(sti_stat[0]), 1);
        clean();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule